// File: doc/BRIEF.md
# Wake-Event Power-Management Output Controller

This block turns wake-up events into a level on a power-management event pin. Four event sources feed it: a received wake-up frame, a received magic packet, a link transition from down to up, and an auxiliary wake source. Each source arrives as a one-cycle pulse synchronous to the block clock and has its own enable bit.

An enabled pulse sets a sticky status bit, and the host clears that bit by writing 1 to it. The pin is driven active while any status bit whose enable is also set remains set. The active level of the pin is programmable.

When auto wake-up is on, the block can also hold the pin inactive until a "clocks ready" input says the chip can take host accesses. Configuration and status share one 16-bit register, which is written through a write strobe and read back continuously.

Top module: `pme_wake_ctrl`

## Requirements
- R1: After reset the register reads 0x0000 and the pin is high (inactive for the reset polarity, which is active low).
- R2: A pulse on event input i with enable bit 8+i set makes status bit i read 1 on the cycle after the pulse. A pulse whose enable is 0 leaves the status unchanged.
- R3: A status bit stays set until a register write carries 1 in that bit position. A write carrying 0 there leaves it set.
- R4: When an enabled event pulse and a write clearing the same status bit happen in the same cycle, the bit ends up set.
- R5: The pin is active only while some status bit i is set together with enable bit 8+i. A set status bit whose enable has been cleared does not drive the pin.
- R6: Bit 12 selects the active level of the pin: 1 means active high and 0 means active low. The inactive level is the opposite one.
- R7: With bit 14 (hold until ready) and bit 7 (auto wake-up) both set, the pin stays inactive while clks_ready is 0. It goes active in the same cycle clks_ready becomes 1.
- R8: With bit 7 clear, bit 14 has no effect, and the pin asserts whatever the value of clks_ready.
- R9: Bits 15, 13 and 6..4 always read 0, and writes to them are ignored. Bits 14, 12, 11..8 and 7 read back as they were written.
- R10: Event input 3 is the wake-up frame, 2 is the magic packet, 1 is the link-up change and 0 is the auxiliary source. Status bit i and enable bit 8+i belong to input i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data; bits 3..0 clear status where 1 |
| cfg_rdata | output | 16 | Register read-back: configuration fields and status bits 3..0 |
| evt_pulse | input | 4 | Wake event pulses: [3] frame, [2] magic packet, [1] link up, [0] auxiliary |
| clks_ready | input | 1 | Clocks are running and host access is possible |
| pme_pin | output | 1 | Power-management event output |

## Verification
Register writes and event pulses take effect at the next clock edge, so read-back and status are due one cycle after the strobe or pulse. The pin is a combinational function of the registered state and clks_ready, so it is due in the same cycle as the status, and a change on clks_ready shows up on the pin before the next edge. The bench drives every input at a falling edge and samples at the next falling edge after the edge that matters. Each result is therefore checked exactly one register stage after its cause, or with no register stage for clks_ready.

// File: rtl/pme_pkg.sv
package pme_pkg;

    localparam int PME_NUM_EVT = 4;
    localparam int PME_REG_W   = 16;

    // Field positions the host and the bench rely on
    localparam int POS_HOLD    = 14;
    localparam int POS_POL     = 12;
    localparam int POS_EN_LO   = 8;
    localparam int POS_AUTO    = 7;
    localparam int POS_STAT_LO = 0;

    // Event input order
    localparam int EVT_AUX   = 0;
    localparam int EVT_LINK  = 1;
    localparam int EVT_MAGIC = 2;
    localparam int EVT_FRAME = 3;

    typedef struct packed {
        logic                   hold_en;
        logic                   pol_high;
        logic [PME_NUM_EVT-1:0] evt_en;
        logic                   auto_wake;
    } pme_cfg_t;

    function automatic pme_cfg_t unpack_cfg(input logic [PME_REG_W-1:0] w);
        pme_cfg_t c;
        c.hold_en   = w[POS_HOLD];
        c.pol_high  = w[POS_POL];
        c.evt_en    = w[POS_EN_LO +: PME_NUM_EVT];
        c.auto_wake = w[POS_AUTO];
        return c;
    endfunction

    function automatic logic [PME_REG_W-1:0] pack_view(input pme_cfg_t c,
                                                       input logic [PME_NUM_EVT-1:0] st);
        logic [PME_REG_W-1:0] w;
        w = '0;
        w[POS_HOLD]                     = c.hold_en;
        w[POS_POL]                      = c.pol_high;
        w[POS_EN_LO +: PME_NUM_EVT]     = c.evt_en;
        w[POS_AUTO]                     = c.auto_wake;
        w[POS_STAT_LO +: PME_NUM_EVT]   = st;
        return w;
    endfunction

endpackage

// File: rtl/pme_cfg_regs.sv
module pme_cfg_regs
    import pme_pkg::*;
#(
    parameter int REG_W = PME_REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output pme_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg <= unpack_cfg(wr_data);
        end
    end

    // R9: configuration moves only on a write
    p_cfg_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));

endmodule

// File: rtl/pme_evt_latch.sv
module pme_evt_latch
    import pme_pkg::*;
#(
    parameter int NUM_EVT = PME_NUM_EVT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] en,
    input  logic [NUM_EVT-1:0] clr,
    output logic [NUM_EVT-1:0] status
);

    logic [NUM_EVT-1:0] status_nx;

    // Setting has priority over clearing in the same cycle
    always_comb begin
        status_nx = (status & ~clr) | (evt & en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= status_nx;
        end
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
        // R2: a status bit only rises from an enabled pulse
        p_set_source_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(status[i]) |-> $past(evt[i] && en[i]));
        // R3: a set bit survives unless a clear was requested
        p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !clr[i]) |=> status[i]);
        // R4: set wins over clear
        p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
            (evt[i] && en[i] && clr[i]) |=> status[i]);
    end

endmodule

// File: rtl/pme_out_stage.sv
module pme_out_stage
    import pme_pkg::*;
#(
    parameter int NUM_EVT = PME_NUM_EVT
) (
    input  logic               clk,
    input  logic               rst,
    input  pme_cfg_t           cfg,
    input  logic [NUM_EVT-1:0] status,
    input  logic               ready,
    output logic               pin
);

    logic pending;
    logic held;
    logic drive;

    always_comb begin
        pending = |(status & cfg.evt_en);
        held    = cfg.hold_en && cfg.auto_wake && !ready;
        drive   = pending && !held;
        pin     = drive ? cfg.pol_high : !cfg.pol_high;
    end

    // R5: nothing enabled pending, pin inactive
    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        ((status & cfg.evt_en) == '0) |-> (pin == !cfg.pol_high));
    // R7: hold keeps the pin inactive until ready
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.hold_en && cfg.auto_wake && !ready) |-> (pin == !cfg.pol_high));
    // R8: without auto wake-up, pending drives the pin regardless of ready
    p_no_auto_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg.auto_wake && ((status & cfg.evt_en) != '0)) |-> (pin == cfg.pol_high));

endmodule

// File: rtl/pme_wake_ctrl.sv
module pme_wake_ctrl
    import pme_pkg::*;
#(
    parameter int NUM_EVT = PME_NUM_EVT,
    parameter int REG_W   = PME_REG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               clks_ready,
    output logic               pme_pin
);

    pme_cfg_t           cfg;
    logic [NUM_EVT-1:0] status;
    logic [NUM_EVT-1:0] clr;

    always_comb begin
        clr = cfg_we ? cfg_wdata[POS_STAT_LO +: NUM_EVT] : '0;
    end

    pme_cfg_regs #(.REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg     (cfg)
    );

    pme_evt_latch #(.NUM_EVT(NUM_EVT)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_pulse),
        .en     (cfg.evt_en),
        .clr    (clr),
        .status (status)
    );

    pme_out_stage #(.NUM_EVT(NUM_EVT)) u_out (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg),
        .status (status),
        .ready  (clks_ready),
        .pin    (pme_pin)
    );

    always_comb begin
        cfg_rdata = pack_view(cfg, status);
    end

    // R9: reserved positions read zero
    p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[15] == 1'b0) && (cfg_rdata[13] == 1'b0) && (cfg_rdata[6:4] == 3'b000));
    // R1: reset leaves the pin high
    p_reset_pin_r1: assert property (@(posedge clk)
        $past(rst) |-> pme_pin);

endmodule

// File: tb/pme_wake_ctrl_test.sv
module pme_wake_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [3:0]  evt_pulse = '0;
    logic        clks_ready = 1'b0;
    logic        pme_pin;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    pme_wake_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .evt_pulse  (evt_pulse),
        .clks_ready (clks_ready),
        .pme_pin    (pme_pin)
    );

    localparam logic [15:0] RW_MASK = 16'h5F80;

    // {cfg[15:0], evt[3:0], ready, exp_pin, exp_status[3:0]}
    localparam int NV = 12;
    localparam logic [25:0] VEC [NV] = '{
        {16'h0F00, 4'b1000, 1'b0, 1'b0, 4'b1000}, // R10 frame, R6 active low
        {16'h1F00, 4'b0100, 1'b0, 1'b1, 4'b0100}, // R10 magic, R6 active high
        {16'h0000, 4'b1111, 1'b0, 1'b1, 4'b0000}, // R2 all disabled
        {16'h0200, 4'b0010, 1'b0, 1'b0, 4'b0010}, // R10 link
        {16'h0100, 4'b0001, 1'b0, 1'b0, 4'b0001}, // R10 aux
        {16'h0800, 4'b0100, 1'b0, 1'b1, 4'b0000}, // R2 wrong enable
        {16'h4F80, 4'b0001, 1'b0, 1'b1, 4'b0001}, // R7 held
        {16'h4F80, 4'b0001, 1'b1, 1'b0, 4'b0001}, // R7 ready
        {16'h4F00, 4'b0001, 1'b0, 1'b0, 4'b0001}, // R8 no auto
        {16'h0F80, 4'b0001, 1'b0, 1'b0, 4'b0001}, // R7 auto without hold
        {16'h5F80, 4'b0010, 1'b0, 1'b0, 4'b0010}, // R7 R6 held, high polarity
        {16'h1F00, 4'b0000, 1'b0, 1'b0, 4'b0000}  // R5 idle, active high
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic pulse(input logic [3:0] e);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        #200000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdata", cfg_rdata, 16'h0000);
        check("R1 pin", {15'd0, pme_pin}, 16'h0001);

        for (int k = 0; k < NV; k++) begin
            logic [25:0] v;
            v = VEC[k];
            reg_write(v[25:10] | 16'h000F);
            clks_ready = v[5];
            pulse(v[9:6]);
            check("R2 R10 status", {12'd0, cfg_rdata[3:0]}, {12'd0, v[3:0]});
            check("R6 R7 R8 pin", {15'd0, pme_pin}, {15'd0, v[4]});
            check("R9 readback", cfg_rdata & 16'hFFF0, v[25:10] & RW_MASK);
        end

        // R3: sticky across idle cycles and a zero write
        reg_write(16'h0F0F);
        clks_ready = 1'b0;
        pulse(4'b0100);
        repeat (4) @(negedge clk);
        check("R3 sticky", {12'd0, cfg_rdata[3:0]}, 16'h0004);
        reg_write(16'h0F00);
        check("R3 zero write keeps", {12'd0, cfg_rdata[3:0]}, 16'h0004);
        reg_write(16'h0F04);
        check("R3 clear", {12'd0, cfg_rdata[3:0]}, 16'h0000);
        check("R5 pin after clear", {15'd0, pme_pin}, 16'h0001);

        // R4: set wins over a same-cycle clear
        pulse(4'b0001);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 16'h0F01; evt_pulse = 4'b0001;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0; evt_pulse = '0;
        check("R4 set wins", {12'd0, cfg_rdata[3:0]}, 16'h0001);

        // R5: disabling the enable releases the pin, status stays
        reg_write(16'h0E00);
        check("R5 status kept", {12'd0, cfg_rdata[3:0]}, 16'h0001);
        check("R5 pin released", {15'd0, pme_pin}, 16'h0001);

        // R7: ready rise releases in the same cycle
        reg_write(16'h4F8F);
        pulse(4'b1000);
        check("R7 held", {15'd0, pme_pin}, 16'h0001);
        #1 clks_ready = 1'b1;
        #0.5;
        check("R7 release", {15'd0, pme_pin}, 16'h0000);
        @(negedge clk);
        clks_ready = 1'b0;

        // R9: write all ones
        reg_write(16'hFFFF);
        check("R9 reserved", cfg_rdata & 16'hFFF0, RW_MASK);

        // R1: reset again mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset again", cfg_rdata, 16'h0000);
        check("R1 pin again", {15'd0, pme_pin}, 16'h0001);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule